// File: doc/BRIEF.md
# Floating-Point Status and Exception Trap Controller

This block owns the floating-point status register of a processor core. It is a registered controller. Each time the arithmetic datapath finishes an operation, the block receives four things: the operation class, the 5-bit set of IEEE exceptions that operation raised, a compare result code, and the low bits of the destination register number. From these it decides whether the operation traps, and it updates the status register on the next clock edge.

The status register holds five fields:
- a trap-enable mask;
- a current-exception field;
- an accrued-exception field;
- four 2-bit compare-result fields;
- a rounding-mode field.

When an enabled exception is raised, the block pulses a trap for one cycle together with a one-hot cause. It also leaves exactly that single cause in the current-exception field. The block also supplies the effective rounding direction to the datapath. That direction can come from the status register, from an override held in a graphics status register, or be forced to round-toward-zero for float-to-integer conversions. Software can load the whole register through a write port.

Top module: `fp_status_unit`

## Requirements
- R1: Operation classes on `op_kind` are: 0 arithmetic, 1 compare, 2 conditional move, 3 float-to-integer. After a non-move operation without a trap, the current-exception field equals exactly the raised set `op_exc` of that operation, with no bits kept from earlier operations.
- R2: An operation other than a conditional move traps when `op_exc & tem` is non-zero. `trap_pulse` is then high in the cycle after the strobe edge and stays low after a strobe whose masked set is zero.
- R3: Exception bits are: 4 invalid, 3 overflow, 2 underflow, 1 divide-by-zero, 0 inexact. On a trap, the current-exception field and `trap_cause` both hold one single bit. That bit is the highest-priority enabled raised exception, with priority running invalid, overflow, underflow, divide-by-zero, inexact.
- R4: Without a trap, the raised set is ORed into the accrued field. On a trap, the accrued field is unchanged.
- R5: A compare that does not trap writes `op_cc` into compare-result field number `op_dst_lo`, and leaves the other three fields unchanged. A trapping compare or any other class writes no compare-result field.
- R6: When `gsr_im` is 1, `eff_rnd` equals `gsr_rnd`. Otherwise it equals the status register rounding field. Encoding: 0 nearest, 1 toward zero, 2 toward +inf, 3 toward -inf.
- R7: While a float-to-integer operation is strobed, `eff_rnd` is 1 (toward zero), whatever the override and the register field hold.
- R8: A conditional move clears the current-exception field. It raises no trap and leaves the accrued, mask and compare-result fields unchanged.
- R9: A synchronous reset clears every status field and the trap outputs.
- R10: The register layout on `stat_q` and `sw_wdata` is: current exceptions [4:0], accrued [9:5], mask [14:10], rounding [16:15], compare field n at [18+2n:17+2n]. With `sw_we` high, the register takes `sw_wdata` at the next edge. A same-cycle operation is then discarded, including its trap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Completed-operation strobe |
| op_kind | input | 2 | Operation class |
| op_exc | input | 5 | Exceptions raised by the operation |
| op_cc | input | 2 | Compare result code |
| op_dst_lo | input | 2 | Low bits of destination register, selects compare field |
| gsr_im | input | 1 | Graphics register rounding-override enable |
| gsr_rnd | input | 2 | Graphics register rounding mode |
| sw_we | input | 1 | Software register write enable |
| sw_wdata | input | 25 | Software write data |
| stat_q | output | 25 | Status register contents |
| trap_pulse | output | 1 | One-cycle trap indication |
| trap_cause | output | 5 | One-hot trap cause |
| eff_rnd | output | 2 | Effective rounding direction |

## Verification
The bench runs operations with several raised sets that overlap the enabled mask, so a priority encoder that keeps the lowest bit, or keeps every enabled bit, shows a multi-bit or wrong cause. It runs trapping compares and checks that the compare-result field is untouched; a design that committed compares unconditionally would overwrite it. It also strobes a trapping operation in the same cycle as a software write, where a design that lets the operation win would corrupt the register and fire a trap. A conditional move carrying raised exceptions shows whether the design wrongly accrues them or traps on them.

// File: rtl/fpsu_pkg.sv
package fpsu_pkg;
    parameter int EXC_W  = 5;
    parameter int NUM_CC = 4;
    parameter int CC_W   = 2;
    parameter int RND_W  = 2;
    localparam int CCSEL_W = $clog2(NUM_CC);

    typedef enum logic [1:0] {
        OP_ARITH = 2'd0,
        OP_CMP   = 2'd1,
        OP_CMOV  = 2'd2,
        OP_F2I   = 2'd3
    } op_kind_e;

    localparam logic [RND_W-1:0] RND_TOWARD_ZERO = 2'd1;

    typedef struct packed {
        logic [NUM_CC-1:0][CC_W-1:0] fcc;
        logic [RND_W-1:0]            rnd;
        logic [EXC_W-1:0]            tem;
        logic [EXC_W-1:0]            aexc;
        logic [EXC_W-1:0]            cexc;
    } stat_t;

    localparam int STAT_W = $bits(stat_t);

    typedef struct packed {
        stat_t            stat;
        logic             trap;
        logic [EXC_W-1:0] cause;
    } ctl_state_t;
endpackage

// File: rtl/fpsu_exc_prio.sv
module fpsu_exc_prio #(
    parameter int W = 5
) (
    input  logic [W-1:0] req,
    output logic [W-1:0] grant
);
    logic [W:0] above;

    assign above[W] = 1'b0;

    for (genvar i = W - 1; i >= 0; i--) begin : g_chain
        assign above[i] = above[i+1] | req[i];
        assign grant[i] = req[i] & ~above[i+1];
    end
endmodule

// File: rtl/fpsu_rnd_sel.sv
module fpsu_rnd_sel #(
    parameter int RW = 2,
    parameter logic [RW-1:0] RZ = '0
) (
    input  logic          force_rz,
    input  logic          ovr_en,
    input  logic [RW-1:0] ovr_rnd,
    input  logic [RW-1:0] base_rnd,
    output logic [RW-1:0] rnd
);
    always_comb begin
        if (force_rz)    rnd = RZ;
        else if (ovr_en) rnd = ovr_rnd;
        else             rnd = base_rnd;
    end
endmodule

// File: rtl/fpsu_cc_bank.sv
module fpsu_cc_bank #(
    parameter int N  = 4,
    parameter int CW = 2,
    localparam int SW = $clog2(N)
) (
    input  logic [N-1:0][CW-1:0] cur,
    input  logic                 we,
    input  logic [SW-1:0]        sel,
    input  logic [CW-1:0]        val,
    output logic [N-1:0][CW-1:0] nxt
);
    for (genvar i = 0; i < N; i++) begin : g_field
        assign nxt[i] = (we && sel == SW'(i)) ? val : cur[i];
    end
endmodule

// File: rtl/fp_status_unit.sv
module fp_status_unit
    import fpsu_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               op_valid,
    input  logic [1:0]         op_kind,
    input  logic [EXC_W-1:0]   op_exc,
    input  logic [CC_W-1:0]    op_cc,
    input  logic [CCSEL_W-1:0] op_dst_lo,
    input  logic               gsr_im,
    input  logic [RND_W-1:0]   gsr_rnd,
    input  logic               sw_we,
    input  logic [STAT_W-1:0]  sw_wdata,
    output logic [STAT_W-1:0]  stat_q,
    output logic               trap_pulse,
    output logic [EXC_W-1:0]   trap_cause,
    output logic [RND_W-1:0]   eff_rnd
);
    ctl_state_t state_d, state_q;
    op_kind_e   kind;
    logic [EXC_W-1:0] hit;
    logic [EXC_W-1:0] first_hit;
    logic             any_hit;
    logic             cc_we;
    logic [NUM_CC-1:0][CC_W-1:0] fcc_nxt;

    assign kind    = op_kind_e'(op_kind);
    assign hit     = op_exc & state_q.stat.tem;
    assign any_hit = |hit;
    assign cc_we   = op_valid && !sw_we && kind == OP_CMP && !any_hit;

    fpsu_exc_prio #(.W(EXC_W)) u_prio (
        .req   (hit),
        .grant (first_hit)
    );

    fpsu_cc_bank #(.N(NUM_CC), .CW(CC_W)) u_cc (
        .cur (state_q.stat.fcc),
        .we  (cc_we),
        .sel (op_dst_lo),
        .val (op_cc),
        .nxt (fcc_nxt)
    );

    fpsu_rnd_sel #(.RW(RND_W), .RZ(RND_TOWARD_ZERO)) u_rnd (
        .force_rz (op_valid && kind == OP_F2I),
        .ovr_en   (gsr_im),
        .ovr_rnd  (gsr_rnd),
        .base_rnd (state_q.stat.rnd),
        .rnd      (eff_rnd)
    );

    always_comb begin
        state_d       = state_q;
        state_d.trap  = 1'b0;
        state_d.cause = '0;
        if (sw_we) begin
            state_d.stat = stat_t'(sw_wdata);
        end else if (op_valid) begin
            if (kind == OP_CMOV) begin
                state_d.stat.cexc = '0;
            end else if (any_hit) begin
                state_d.stat.cexc = first_hit;
                state_d.trap      = 1'b1;
                state_d.cause     = first_hit;
            end else begin
                state_d.stat.cexc = op_exc;
                state_d.stat.aexc = state_q.stat.aexc | op_exc;
                state_d.stat.fcc  = fcc_nxt;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= '0;
        else     state_q <= state_d;
    end

    assign stat_q     = state_q.stat;
    assign trap_pulse = state_q.trap;
    assign trap_cause = state_q.cause;
endmodule

// File: rtl/fp_status_unit_chk.sv
module fp_status_unit_chk
    import fpsu_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               op_valid,
    input logic [1:0]         op_kind,
    input logic [EXC_W-1:0]   op_exc,
    input logic [CC_W-1:0]    op_cc,
    input logic [CCSEL_W-1:0] op_dst_lo,
    input logic               gsr_im,
    input logic [RND_W-1:0]   gsr_rnd,
    input logic               sw_we,
    input logic [STAT_W-1:0]  sw_wdata,
    input logic [STAT_W-1:0]  stat_q,
    input logic               trap_pulse,
    input logic [EXC_W-1:0]   trap_cause,
    input logic [RND_W-1:0]   eff_rnd
);
    stat_t s;
    logic  live_op;
    assign s       = stat_t'(stat_q);
    assign live_op = op_valid && !sw_we && op_kind != 2'd2;

    p_trap_when_enabled_r2: assert property (@(posedge clk) disable iff (rst)
        live_op && |(op_exc & s.tem) |=> trap_pulse);

    p_no_trap_when_masked_r2: assert property (@(posedge clk) disable iff (rst)
        live_op && (op_exc & s.tem) == '0 |=> !trap_pulse);

    p_cause_single_r3: assert property (@(posedge clk) disable iff (rst)
        trap_pulse |-> $countones(trap_cause) == 1 && s.cexc == trap_cause);

    p_accrued_frozen_r4: assert property (@(posedge clk) disable iff (rst)
        live_op && |(op_exc & s.tem) |=> $stable(s.aexc));

    p_fcc_frozen_on_trap_r5: assert property (@(posedge clk) disable iff (rst)
        live_op && |(op_exc & s.tem) |=> $stable(s.fcc));

    p_f2i_toward_zero_r7: assert property (@(posedge clk) disable iff (rst)
        op_valid && op_kind == 2'd3 |-> eff_rnd == RND_TOWARD_ZERO);

    p_cmov_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        op_valid && !sw_we && op_kind == 2'd2 |=>
            s.cexc == '0 && !trap_pulse && $stable(s.aexc));

    p_sw_write_wins_r10: assert property (@(posedge clk) disable iff (rst)
        sw_we |=> stat_q == $past(sw_wdata) && !trap_pulse);
endmodule

bind fp_status_unit fp_status_unit_chk u_chk (.*);

// File: tb/fp_status_unit_tb.sv
module fp_status_unit_tb;
    import fpsu_pkg::*;

    localparam int CLK_P = 10;
    localparam int NV    = 12;
    // {kind[1:0], exc[4:0], cc[1:0], dst[1:0]}
    localparam logic [10:0] VEC [NV] = '{
        {2'd0, 5'b00001, 2'd0, 2'd0},
        {2'd0, 5'b01100, 2'd0, 2'd0},
        {2'd1, 5'b00000, 2'd2, 2'd3},
        {2'd1, 5'b10000, 2'd1, 2'd0},
        {2'd0, 5'b11111, 2'd0, 2'd0},
        {2'd0, 5'b00011, 2'd0, 2'd0},
        {2'd2, 5'b11111, 2'd0, 2'd0},
        {2'd3, 5'b00001, 2'd0, 2'd0},
        {2'd1, 5'b00001, 2'd3, 2'd1},
        {2'd1, 5'b00000, 2'd1, 2'd2},
        {2'd0, 5'b00101, 2'd0, 2'd0},
        {2'd0, 5'b01000, 2'd0, 2'd0}
    };

    logic clk = 0, rst = 1;
    logic op_valid = 0;
    logic [1:0] op_kind = 0;
    logic [4:0] op_exc = 0;
    logic [1:0] op_cc = 0, op_dst_lo = 0;
    logic gsr_im = 0;
    logic [1:0] gsr_rnd = 0;
    logic sw_we = 0;
    logic [STAT_W-1:0] sw_wdata = 0;
    logic [STAT_W-1:0] stat_q;
    logic trap_pulse;
    logic [4:0] trap_cause;
    logic [1:0] eff_rnd;

    int checks = 0, fails = 0;
    bit done = 0;

    // bench model of the register
    logic [4:0] m_cexc, m_aexc, m_tem;
    logic [1:0] m_rnd;
    logic [1:0] m_fcc [4];
    logic       m_trap;
    logic [4:0] m_cause;

    always #(CLK_P/2) clk = ~clk;

    fp_status_unit u_dut (.*);

    function automatic logic [STAT_W-1:0] m_pack();
        return {m_fcc[3], m_fcc[2], m_fcc[1], m_fcc[0], m_rnd, m_tem, m_aexc, m_cexc};
    endfunction

    task automatic m_clear();
        m_cexc = 0; m_aexc = 0; m_tem = 0; m_rnd = 0; m_trap = 0; m_cause = 0;
        for (int i = 0; i < 4; i++) m_fcc[i] = 0;
    endtask

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic sw_write(logic [STAT_W-1:0] v);
        @(negedge clk);
        sw_we = 1; sw_wdata = v;
        @(negedge clk);
        sw_we = 0;
        {m_fcc[3], m_fcc[2], m_fcc[1], m_fcc[0], m_rnd, m_tem, m_aexc, m_cexc} = v;
        m_trap = 0; m_cause = 0;
    endtask

    task automatic run_vec(logic [10:0] v);
        logic [4:0] hit, pick;
        op_valid = 1;
        {op_kind, op_exc, op_cc, op_dst_lo} = v;
        hit = op_exc & m_tem;
        pick = 0;
        for (int b = 4; b >= 0; b--)
            if (hit[b] && pick == 0) pick[b] = 1'b1;
        m_trap = 0; m_cause = 0;
        if (op_kind == 2'd2) m_cexc = 0;
        else if (hit != 0) begin
            m_cexc = pick; m_trap = 1; m_cause = pick;
        end else begin
            m_cexc = op_exc; m_aexc = m_aexc | op_exc;
            if (op_kind == 2'd1) m_fcc[op_dst_lo] = op_cc;
        end
        @(negedge clk);
        op_valid = 0;
        check("R1/R3/R4/R5/R8 stat", 32'(stat_q), 32'(m_pack()));
        check("R2/R3 trap", {26'd0, trap_pulse, trap_cause}, {26'd0, m_trap, m_cause});
    endtask

    initial begin
        m_clear();
        repeat (3) @(negedge clk);
        // R9 reset state
        check("R9 reset stat", 32'(stat_q), 0);
        check("R9 reset trap", {31'd0, trap_pulse}, 0);
        rst = 0;

        // pass 1: invalid and divide-by-zero enabled
        sw_write(25'(5'b10010) << 10);
        for (int i = 0; i < NV; i++) run_vec(VEC[i]);
        // pass 2: overflow and underflow enabled
        sw_write(25'(5'b01100) << 10);
        for (int i = 0; i < NV; i++) run_vec(VEC[i]);

        // R2 trap lasts one cycle
        run_vec({2'd0, 5'b01000, 2'd0, 2'd0});
        @(negedge clk);
        check("R2 pulse drops", {31'd0, trap_pulse}, 0);

        // R6 rounding selection, R7 forced toward zero
        sw_write(25'(2'd2) << 15);
        check("R6 base rnd", 32'(eff_rnd), 2);
        gsr_im = 1; gsr_rnd = 3; #1;
        check("R6 override rnd", 32'(eff_rnd), 3);
        op_valid = 1; op_kind = 2'd3; op_exc = 0; #1;
        check("R7 f2i toward zero", 32'(eff_rnd), 1);
        op_valid = 0; gsr_im = 0; #1;

        // R10 software write beats a trapping operation
        sw_write(25'(5'b11111) << 10);
        m_trap = 0;
        @(negedge clk);
        sw_we = 1; sw_wdata = 25'h1ABCDEF & {STAT_W{1'b1}};
        op_valid = 1; op_kind = 0; op_exc = 5'b10000;
        @(negedge clk);
        sw_we = 0; op_valid = 0;
        check("R10 sw wins stat", 32'(stat_q), 32'(25'h1ABCDEF));
        check("R10 sw wins no trap", {31'd0, trap_pulse}, 0);

        // R9 mid-run reset
        rst = 1;
        @(negedge clk);
        check("R9 reset clears", 32'(stat_q), 0);
        rst = 0;

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        #(CLK_P * 20000);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog act=hung exp=done");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule